// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block builds IEEE 802.3x MAC control pause frames and sends them one byte per beat on a streaming output. An XOFF frame asks the link partner to stop sending for a programmed number of pause quanta. An XON frame carries a quanta of zero and lets traffic resume. The block does not append the frame check sequence; a later stage adds it.

Two sources can ask for a frame. The first is a 2-bit client request input. The second is a host trigger register. A mode register selects which source the block listens to, and it ignores the other one. Software programs the mode, the quanta and the 48-bit station address through a simple write port. In client mode an XON frame goes out only once after each XOFF frame. This keeps a held resume request from flooding the link. Requests that arrive while a frame is on the wire are latched and served after its last byte.

The output uses valid/ready handshaking. A byte moves only on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, the block holds the byte and its markers unchanged. The block never withdraws `tx_valid` in the middle of a frame.

Top module: `pause_frame_gen`

## Requirements
- R1: Each frame is `FRAME_LEN` (60) bytes, most significant byte first, in this order:
  - bytes 0–5: the destination address 01-80-C2-00-00-01;
  - bytes 6–11: the source address, where register 3 holds address bits [31:0] and register 4 bits [15:0] hold address bits [47:32];
  - bytes 12–13: the type 0x8808;
  - bytes 14–15: the opcode 0x0001;
  - bytes 16–17: the 16-bit quanta;
  - bytes 18 to `FRAME_LEN`-1: zero.
- R2: An XOFF frame carries the quanta held in register 2 bits [15:0] (reset value 0xFFFF). An XON frame carries quanta 0.
- R3: In client mode (register 1 bit 0 = 0), `client_req[1]` high requests an XOFF frame and `client_req[0]` high requests an XON frame.
- R4: In client mode, an XON request is honoured only when an XOFF frame has completed since reset or since the last XON frame. Any other XON request is dropped, so holding `client_req[0]` high yields exactly one XON frame.
- R5: In host mode (register 1 bit 0 = 1), each write to register 0 with bit 1 set yields one XOFF frame and with bit 0 set yields one XON frame. The trigger clears itself, and host XON frames need no preceding XOFF frame.
- R6: The block ignores the source that the mode does not select: client requests in host mode and trigger writes in client mode produce no frame.
- R7: When XOFF and XON are both pending, the block sends the XOFF frame first and then the XON frame.
- R8: A request that arrives while a frame is being sent is held and served after that frame's end-of-packet.
- R9: A byte advances only when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data`, `tx_sop` and `tx_eop` stay stable. `tx_sop` marks byte 0 and `tx_eop` marks byte `FRAME_LEN`-1.
- R10: Reset clears all pending requests and the XOFF-sent state, and `tx_valid` is low after reset. An XON request right after reset therefore produces no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| client_req | input | 2 | Client request: bit 1 XOFF, bit 0 XON (level) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 trigger, 1 mode, 2 quanta, 3 address low, 4 address high |
| wr_data | input | 32 | Register write data |
| tx_ready | input | 1 | Downstream ready |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |

## Verification
The bench builds the block with its default parameters: a 60-byte frame, a 3-bit register address and 32-bit write data. With these values every padding byte up to byte 59 appears on the wire and is compared. The full 48-bit station address can be written in two words. Back-to-back frames, a stalling receiver and a change of trigger source can all be driven at the block's own ports.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic {KIND_XOFF = 1'b0, KIND_XON = 1'b1} pause_kind_e;

  typedef enum logic [2:0] {
    RA_TRIG   = 3'd0,
    RA_MODE   = 3'd1,
    RA_QUANTA = 3'd2,
    RA_SA_LO  = 3'd3,
    RA_SA_HI  = 3'd4
  } reg_addr_e;

  localparam logic [47:0] PAUSE_DST     = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETHTYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
  localparam int          HDR_BYTES     = 18;
  localparam logic [15:0] QUANTA_RESET  = 16'hFFFF;
endpackage

// File: rtl/pfg_regs.sv
module pfg_regs
  import pfg_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              host_mode,
  output logic [15:0]       quanta,
  output logic [47:0]       src_addr,
  output logic [1:0]        host_trig
);
  logic hit_trig, hit_mode, hit_q, hit_lo, hit_hi;

  assign hit_trig = wr_en && (wr_addr == REG_AW'(RA_TRIG));
  assign hit_mode = wr_en && (wr_addr == REG_AW'(RA_MODE));
  assign hit_q    = wr_en && (wr_addr == REG_AW'(RA_QUANTA));
  assign hit_lo   = wr_en && (wr_addr == REG_AW'(RA_SA_LO));
  assign hit_hi   = wr_en && (wr_addr == REG_AW'(RA_SA_HI));

  // trigger bits are a one-cycle strobe; the request logic holds them
  assign host_trig = hit_trig ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_mode <= 1'b0;
      quanta    <= QUANTA_RESET;
      src_addr  <= '0;
    end else begin
      if (hit_mode) host_mode       <= wr_data[0];
      if (hit_q)    quanta          <= wr_data[15:0];
      if (hit_lo)   src_addr[31:0]  <= wr_data[31:0];
      if (hit_hi)   src_addr[47:32] <= wr_data[15:0];
    end
  end
endmodule

// File: rtl/pfg_req.sv
module pfg_req
  import pfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_mode,
  input  logic [1:0]  client_req,
  input  logic [1:0]  host_trig,
  input  logic        busy,
  input  logic        done,
  input  pause_kind_e done_kind,
  output logic        start,
  output pause_kind_e start_kind
);
  logic pend_xoff, pend_xon, armed;
  logic src_xoff, src_xon, xon_gate;
  logic take_xoff, take_xon;

  assign start      = !busy && (pend_xoff || pend_xon);
  assign start_kind = pend_xoff ? KIND_XOFF : KIND_XON;
  assign take_xoff  = start && (start_kind == KIND_XOFF);
  assign take_xon   = start && (start_kind == KIND_XON);

  assign src_xoff = host_mode ? host_trig[1] : client_req[1];
  // client XON only while armed, and not in the cycle the armed XON launches
  assign xon_gate = host_mode || (armed && !take_xon);
  assign src_xon  = (host_mode ? host_trig[0] : client_req[0]) && xon_gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_xoff <= 1'b0;
      pend_xon  <= 1'b0;
      armed     <= 1'b0;
    end else begin
      pend_xoff <= (pend_xoff && !take_xoff) || src_xoff;
      pend_xon  <= (pend_xon && !take_xon) || src_xon;
      if (take_xon)
        armed <= 1'b0;
      else if (done && done_kind == KIND_XOFF)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
  import pfg_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  pause_kind_e start_kind,
  input  logic [15:0] quanta,
  input  logic [47:0] src_addr,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        busy,
  output logic        done,
  output pause_kind_e done_kind
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam int HDR_W = HDR_BYTES * 8;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] idx;
  pause_kind_e      kind_q;
  logic [15:0]      quanta_q;
  logic [47:0]      sa_q;
  logic [HDR_W-1:0] hdr_vec;
  logic [7:0]       byte_sel [HDR_BYTES];
  logic [7:0]       hdr_byte;

  assign hdr_vec = {PAUSE_DST, sa_q, CTRL_ETHTYPE, PAUSE_OPCODE, quanta_q};

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign byte_sel[g] = (idx == CNT_W'(g)) ? hdr_vec[(HDR_BYTES-1-g)*8 +: 8] : 8'h00;
  end

  always_comb begin
    hdr_byte = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) hdr_byte = hdr_byte | byte_sel[i];
  end

  assign tx_valid  = busy;
  assign tx_data   = busy ? hdr_byte : 8'h00;
  assign tx_sop    = busy && (idx == '0);
  assign tx_eop    = busy && (idx == LAST);
  assign done      = tx_eop && tx_ready;
  assign done_kind = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      kind_q   <= KIND_XOFF;
      quanta_q <= '0;
      sa_q     <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx      <= '0;
      kind_q   <= start_kind;
      quanta_q <= (start_kind == KIND_XON) ? 16'h0000 : quanta;
      sa_q     <= src_addr;
    end else if (busy && tx_ready) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  parameter int REG_AW    = 3,
  parameter int REG_DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        client_req,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sop,
  output logic              tx_eop
);
  logic        host_mode;
  logic [15:0] quanta;
  logic [47:0] src_addr;
  logic [1:0]  host_trig;
  logic        busy, done, start;
  pause_kind_e done_kind, start_kind;

  pfg_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .host_mode(host_mode), .quanta(quanta), .src_addr(src_addr), .host_trig(host_trig)
  );

  pfg_req u_req (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .client_req(client_req),
    .host_trig(host_trig), .busy(busy), .done(done), .done_kind(done_kind),
    .start(start), .start_kind(start_kind)
  );

  pfg_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
    .quanta(quanta), .src_addr(src_addr), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .busy(busy), .done(done), .done_kind(done_kind)
  );
endmodule

// File: rtl/pause_frame_gen_chk.sv
module pause_frame_gen_chk #(
  parameter int FRAME_LEN = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_sop,
  input logic       tx_eop
);
  localparam int CW = $clog2(FRAME_LEN + 1);
  logic [CW-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n)                   beat <= '0;
    else if (tx_valid && tx_ready) beat <= tx_eop ? '0 : beat + 1'b1;
  end

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));
  // R9
  sop_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_sop == (beat == '0)));
  // R1
  eop_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_eop == (beat == CW'(FRAME_LEN - 1))));
  // R1
  dst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data == 8'h01);
  // R1
  ethtype_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && beat == CW'(12) |-> tx_data == 8'h88);
  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && beat >= CW'(18) |-> tx_data == 8'h00);
  // R10
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !tx_valid);
endmodule

bind pause_frame_gen pause_frame_gen_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
);

// File: tb/pause_frame_gen_bench.sv
module pause_frame_gen_bench;
  localparam int FL = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  client_req = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tx_ready = 1'b1;
  logic        tx_valid, tx_sop, tx_eop;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] rx_buf [FL];
  bit rx_got, rx_marks;
  logic [47:0] cur_sa;
  logic [15:0] cur_q;

  always #5 clk = ~clk;

  pause_frame_gen u_pause_frame_gen (
    .clk(clk), .rst_n(rst_n), .client_req(client_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  function automatic logic [7:0] exp_byte(input bit xon, input logic [15:0] q,
                                          input logic [47:0] sa, input int i);
    logic [143:0] v;
    v = {48'h0180C2000001, sa, 16'h8808, 16'h0001, (xon ? 16'h0000 : q)};
    if (i < 18) return v[(17 - i) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] r);
    @(negedge clk); client_req = r;
    @(negedge clk); client_req = 2'b00;
  endtask

  task automatic recv_frame(input bit stall);
    int n = 0;
    int cyc = 0;
    rx_marks = 1'b1;
    while (n < FL && cyc < 600) begin
      @(negedge clk);
      tx_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      if (tx_valid && tx_ready) begin
        if (tx_sop != (n == 0) || tx_eop != (n == FL - 1)) rx_marks = 1'b0;
        rx_buf[n] = tx_data;
        n++;
      end
    end
    rx_got = (n == FL);
    tx_ready = 1'b1;
  endtask

  task automatic check_frame(input string tag, input bit xon);
    int bad = -1;
    checks++;
    if (!rx_got) begin
      errors++;
      $display("FAIL %s: frame not received, actual none expected %s", tag, xon ? "XON" : "XOFF");
      return;
    end
    for (int i = 0; i < FL; i++)
      if (bad < 0 && rx_buf[i] !== exp_byte(xon, cur_q, cur_sa, i)) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: byte %0d actual %02h expected %02h", tag, bad, rx_buf[bad],
               exp_byte(xon, cur_q, cur_sa, bad));
    end else if (!rx_marks) begin
      errors++;
      $display("FAIL %s: sop/eop markers actual misplaced expected bytes 0 and %0d", tag, FL - 1);
    end
  endtask

  task automatic check_idle(input string tag, input int cycles);
    int seen = 0;
    checks++;
    tx_ready = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    if (seen != 0) begin
      errors++;
      $display("FAIL %s: valid beats actual %0d expected 0", tag, seen);
    end
  endtask

  task automatic t_reset_state;
    checks++;
    if (tx_valid !== 1'b0 || tx_sop !== 1'b0 || tx_eop !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: valid/sop/eop actual %b%b%b expected 000", tx_valid, tx_sop, tx_eop);
    end
  endtask

  task automatic t_xon_unarmed;
    pulse(2'b01);
    check_idle("R4 R10 XON before any XOFF", 40);
  endtask

  task automatic t_client_xoff;
    pulse(2'b10);
    recv_frame(1'b0);
    check_frame("R1 R2 R3 client XOFF", 1'b0);
  endtask

  task automatic t_xon_once;
    @(negedge clk); client_req = 2'b01;
    recv_frame(1'b0);
    check_frame("R2 R3 client XON", 1'b1);
    check_idle("R4 XON held, no second frame", 100);
    client_req = 2'b00;
  endtask

  task automatic t_priority;
    pulse(2'b10);
    recv_frame(1'b0);
    check_frame("R7 arming XOFF", 1'b0);
    pulse(2'b11);
    recv_frame(1'b0);
    check_frame("R7 XOFF first", 1'b0);
    recv_frame(1'b0);
    check_frame("R7 XON second", 1'b1);
  endtask

  task automatic t_pending_and_stall;
    pulse(2'b10);
    fork
      recv_frame(1'b0);
      begin repeat (12) @(negedge clk); client_req = 2'b10; @(negedge clk); client_req = 2'b00; end
    join
    check_frame("R8 first XOFF", 1'b0);
    recv_frame(1'b1);
    check_frame("R8 R9 held XOFF under back-pressure", 1'b0);
    pulse(2'b01);
    recv_frame(1'b1);
    check_frame("R9 XON under back-pressure", 1'b1);
  endtask

  task automatic t_host_mode;
    wr(3'd1, 32'h1);
    pulse(2'b10);
    check_idle("R6 client ignored in host mode", 40);
    cur_q = 16'hABCD;
    wr(3'd2, 32'h0000ABCD);
    wr(3'd0, 32'h2);
    recv_frame(1'b0);
    check_frame("R5 host XOFF", 1'b0);
    wr(3'd0, 32'h1);
    recv_frame(1'b0);
    check_frame("R5 host XON", 1'b1);
    check_idle("R5 trigger self-clears", 40);
    wr(3'd0, 32'h1);
    recv_frame(1'b0);
    check_frame("R5 host XON without XOFF", 1'b1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h2);
    check_idle("R6 trigger ignored in client mode", 40);
  endtask

  task automatic t_reset_clears;
    pulse(2'b10);
    recv_frame(1'b0);
    check_frame("R10 XOFF before reset", 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset_state();
    pulse(2'b01);
    check_idle("R10 armed state cleared", 40);
  endtask

  initial begin
    cur_sa = 48'h1122_3344_5566;
    cur_q  = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    wr(3'd3, 32'h33445566);
    wr(3'd4, 32'h00001122);
    wr(3'd2, 32'h00001234);
    t_xon_unarmed();
    t_client_xoff();
    t_xon_once();
    t_priority();
    t_pending_and_stall();
    t_host_mode();
    t_reset_clears();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule